// File: doc/BRIEF.md
# Page Access Gate for Two-Level Virtual Memory

This block makes the per-access decision that a memory management unit needs once a leaf page-table entry is in hand. For every request it works out which privilege level governs the access and whether address translation applies at all. When translation does apply, it checks the leaf entry's flags against the access and reports a page fault if they do not permit it. Walking the page table, storing translations and forming the physical address are left to neighbouring logic.

The governing privilege is normally the hart's current level. When the modify-privilege bit in the status word is set, loads and stores instead use the previous-privilege field, while instruction fetches keep the current level. Machine-mode fetches are never translated. Machine-mode data accesses are translated only under modify-privilege. Both results are registered and appear one cycle after a request strobe. The fault result is forced low whenever translation is bypassed.

Top module: `vm_access_gate`

## Requirements
- R1: After reset `rsp_valid`, `rsp_bypass` and `rsp_fault` are 0. `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` 1. The result outputs change only in that cycle and hold their values otherwise.
- R2: The governing privilege is the previous-privilege field when modify-privilege is 1 and `kind` is not execute. Otherwise it is `cur_priv`. Privilege codes are 0 user, 1 supervisor and 3 machine. Kind codes are 0 read, 1 write and 2 execute.
- R3: `rsp_bypass` is 1 when the governing privilege is 3 or when `xlate_on` is 0.
- R4: When `cur_priv` is 3 and `ifetch_port` is 1, `rsp_bypass` is 1 regardless of modify-privilege. When `cur_priv` is 3 and `ifetch_port` is 0, translation applies only with modify-privilege set and a previous-privilege field below 3.
- R5: `rsp_fault` is 0 whenever `rsp_bypass` is 1, whatever the entry flags.
- R6: In `pte_flags`, bit 0 is valid, bit 1 is readable, bit 2 is writable, bit 3 is executable and bit 4 is user. A translated access to an entry whose valid bit is 0 faults.
- R7: A translated access under governing privilege 0 to an entry whose user bit is 0 faults.
- R8: A translated access under governing privilege 1 to an entry whose user bit is 1 faults when the supervisor-user-access bit is 0, and is allowed by this rule when that bit is 1.
- R9: When `pte_level` is 1 (first-level superpage) and `pte_ppn0` is nonzero, a translated access faults. At level 0, `pte_ppn0` has no effect.
- R10: A read needs readable, or executable with make-executable-readable set. A write needs writable. An execute needs executable. Kind code 3 always faults when translated.
- R11: The status fields are taken from `status` bits [12:11] (previous privilege), 17 (modify-privilege), 18 (supervisor-user-access) and 19 (make-executable-readable). All other status bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe; inputs are sampled when it is 1 |
| cur_priv | input | 2 | Current privilege level |
| status | input | 32 | Machine status word |
| xlate_on | input | 1 | Translation mode enabled |
| kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| ifetch_port | input | 1 | 1 for the instruction port, 0 for the data port |
| pte_flags | input | 5 | Leaf entry flags: valid, readable, writable, executable, user |
| pte_level | input | 1 | 1 when the leaf is a first-level superpage |
| pte_ppn0 | input | 10 | Low physical page number field of the leaf |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_bypass | output | 1 | Translation does not apply |
| rsp_fault | output | 1 | Page fault |

## Verification
The bench builds the block with its default parameters: a 32-bit status word with the fields at bits 11, 17, 18 and 19, and a 10-bit low page-number field. With these values, all ones in every unrelated status bit can be tested to confirm R11, and a nonzero low page number can be tested at both levels. Back-to-back requests followed by an idle gap exercise the one-cycle response and the hold behaviour. Each fault rule is isolated with an entry that satisfies every other rule, including requests where modify-privilege changes the governing level in machine and supervisor mode.

// File: rtl/vm_gate_pkg.sv
// Shared codes for the page access gate.
// Assumes the two-level page-table flag layout and the usual privilege codes.
package vm_gate_pkg;
    localparam int PTE_FLAG_W = 5;
    localparam int FLG_V = 0;
    localparam int FLG_R = 1;
    localparam int FLG_W = 2;
    localparam int FLG_X = 3;
    localparam int FLG_U = 4;

    localparam logic [1:0] PRIV_USER  = 2'd0;
    localparam logic [1:0] PRIV_SUPER = 2'd1;
    localparam logic [1:0] PRIV_MACH  = 2'd3;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_EXEC  = 2'd2;
endpackage

// File: rtl/vm_priv_select.sv
// Picks the privilege that governs an access and decides whether translation is skipped.
// Assumes the status fields were already extracted by the caller. Purely combinational.
module vm_priv_select
    import vm_gate_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic [1:0] prev_priv,
    input  logic       mod_priv,
    input  logic       xlate_on,
    input  logic [1:0] kind,
    input  logic       ifetch_port,
    output logic [1:0] eff_priv,
    output logic       bypass
);
    logic mach_fetch;

    // Loads and stores borrow the previous privilege under modify-privilege.
    always_comb begin
        if (mod_priv && (kind != KIND_EXEC)) eff_priv = prev_priv;
        else                                 eff_priv = cur_priv;
    end

    // Machine instruction-port accesses are never translated.
    always_comb mach_fetch = (cur_priv == PRIV_MACH) && ifetch_port;

    // Skip translation when off, when governed as machine, or for machine fetches.
    always_comb bypass = !xlate_on || (eff_priv == PRIV_MACH) || mach_fetch;
endmodule

// File: rtl/vm_perm_check.sv
// Evaluates a leaf page-table entry against one access and reports a raw fault.
// Assumes the caller masks the result when translation is bypassed.
module vm_perm_check
    import vm_gate_pkg::*;
#(
    parameter int PPN0_W = 10
) (
    input  logic [1:0]            eff_priv,
    input  logic [1:0]            kind,
    input  logic                  sum_bit,
    input  logic                  mxr_bit,
    input  logic [PTE_FLAG_W-1:0] pte_flags,
    input  logic                  pte_level,
    input  logic [PPN0_W-1:0]     pte_ppn0,
    output logic                  fault
);
    logic invalid, user_deny, super_deny, misaligned, kind_deny;

    // The entry must be valid.
    always_comb invalid = !pte_flags[FLG_V];

    // User level may only touch user pages.
    always_comb user_deny = !pte_flags[FLG_U] && (eff_priv == PRIV_USER);

    // Supervisor level needs permission to touch user pages.
    always_comb super_deny = pte_flags[FLG_U] && (eff_priv == PRIV_SUPER) && !sum_bit;

    // A superpage must be aligned on its low page-number field.
    always_comb misaligned = pte_level && (pte_ppn0 != '0);

    // Each access kind needs its own permission flag.
    always_comb begin
        unique case (kind)
            KIND_READ:  kind_deny = !(pte_flags[FLG_R] || (mxr_bit && pte_flags[FLG_X]));
            KIND_WRITE: kind_deny = !pte_flags[FLG_W];
            KIND_EXEC:  kind_deny = !pte_flags[FLG_X];
            default:    kind_deny = 1'b1;
        endcase
    end

    // Any failed rule raises a fault.
    always_comb fault = invalid || user_deny || super_deny || misaligned || kind_deny;
endmodule

// File: rtl/vm_access_gate.sv
// Top of the page access gate: extracts the status fields, combines the privilege
// selection with the permission check, and registers the result one cycle after a
// request. Assumes the leaf entry presented with the request is the final one.
module vm_access_gate
    import vm_gate_pkg::*;
#(
    parameter int STATUS_W = 32,
    parameter int PPN0_W   = 10,
    parameter int MPP_LSB  = 11,
    parameter int MPRV_BIT = 17,
    parameter int SUM_BIT  = 18,
    parameter int MXR_BIT  = 19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            cur_priv,
    input  logic [STATUS_W-1:0]   status,
    input  logic                  xlate_on,
    input  logic [1:0]            kind,
    input  logic                  ifetch_port,
    input  logic [PTE_FLAG_W-1:0] pte_flags,
    input  logic                  pte_level,
    input  logic [PPN0_W-1:0]     pte_ppn0,
    output logic                  rsp_valid,
    output logic                  rsp_bypass,
    output logic                  rsp_fault
);
    localparam int MPP_MSB = MPP_LSB + 1;

    logic [1:0] prev_priv, eff_priv;
    logic       mod_priv, sum_bit, mxr_bit;
    logic       bypass, raw_fault, fault_d;
    logic       status_unused;

    // Pull the status fields out of the status word.
    always_comb begin
        prev_priv = status[MPP_MSB:MPP_LSB];
        mod_priv  = status[MPRV_BIT];
        sum_bit   = status[SUM_BIT];
        mxr_bit   = status[MXR_BIT];
    end

    // Other status bits are deliberately left unused.
    assign status_unused = ^status;

    vm_priv_select u_priv (
        .cur_priv   (cur_priv),
        .prev_priv  (prev_priv),
        .mod_priv   (mod_priv),
        .xlate_on   (xlate_on),
        .kind       (kind),
        .ifetch_port(ifetch_port),
        .eff_priv   (eff_priv),
        .bypass     (bypass)
    );

    vm_perm_check #(.PPN0_W(PPN0_W)) u_perm (
        .eff_priv (eff_priv),
        .kind     (kind),
        .sum_bit  (sum_bit),
        .mxr_bit  (mxr_bit),
        .pte_flags(pte_flags),
        .pte_level(pte_level),
        .pte_ppn0 (pte_ppn0),
        .fault    (raw_fault)
    );

    // A bypassed access can never fault.
    always_comb fault_d = raw_fault && !bypass;

    // Capture the decision on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_bypass <= 1'b0;
            rsp_fault  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_bypass <= bypass;
                rsp_fault  <= fault_d;
            end
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_bypass) && $stable(rsp_fault))); // R1
    AST_XLATE_OFF_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlate_on) |=> rsp_bypass); // R3
    AST_MACH_FETCH_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_priv == PRIV_MACH && ifetch_port) |=> rsp_bypass); // R4
    AST_FAULT_NOT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_bypass && rsp_fault)); // R5
    AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_on && cur_priv != PRIV_MACH && !status[MPRV_BIT]
         && !pte_flags[FLG_V]) |=> rsp_fault); // R6
    AST_USER_PAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_on && cur_priv == PRIV_USER && !status[MPRV_BIT]
         && !pte_flags[FLG_U]) |=> rsp_fault); // R7
    AST_WRITE_NEEDS_W: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_on && cur_priv != PRIV_MACH && !status[MPRV_BIT]
         && kind == KIND_WRITE && !pte_flags[FLG_W]) |=> rsp_fault); // R10
endmodule

// File: tb/test_vm_access_gate.sv
`timescale 1ns/1ps
module test_vm_access_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] cur_priv = '0;
    logic [31:0] status = '0;
    logic       xlate_on = 1'b0;
    logic [1:0] kind = '0;
    logic       ifetch_port = 1'b0;
    logic [4:0] pte_flags = '0;
    logic       pte_level = 1'b0;
    logic [9:0] pte_ppn0 = '0;
    logic       rsp_valid, rsp_bypass, rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct { logic byp; logic flt; string tag; } exp_t;
    exp_t sb[$];

    localparam logic [4:0] V = 5'h01, R = 5'h02, W = 5'h04, X = 5'h08, U = 5'h10;
    localparam logic [31:0] FIELD_MASK = 32'h000E_1800;

    always #4 clk = ~clk;

    vm_access_gate i_vm_access_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_priv(cur_priv),
        .status(status), .xlate_on(xlate_on), .kind(kind), .ifetch_port(ifetch_port),
        .pte_flags(pte_flags), .pte_level(pte_level), .pte_ppn0(pte_ppn0),
        .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass), .rsp_fault(rsp_fault)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Expected result written from the requirement text.
    function automatic void predict(input logic [1:0] cp, input logic [1:0] mpp, input logic mprv,
                                    input logic sum, input logic mxr, input logic xon,
                                    input logic [1:0] k, input logic ifp, input logic [4:0] f,
                                    input logic lvl, input logic [9:0] p0,
                                    output logic byp, output logic flt);
        logic [1:0] gov;
        logic ok;
        gov = cp;
        if (mprv && k != 2'd2) gov = mpp;
        byp = (!xon) || (gov == 2'd3) || (cp == 2'd3 && ifp);
        ok = f[0];
        if (gov == 2'd0 && !f[4]) ok = 0;
        if (gov == 2'd1 && f[4] && !sum) ok = 0;
        if (lvl && p0 != 0) ok = 0;
        case (k)
            2'd0: if (!(f[1] || (f[3] && mxr))) ok = 0;
            2'd1: if (!f[2]) ok = 0;
            2'd2: if (!f[3]) ok = 0;
            default: ok = 0;
        endcase
        flt = byp ? 1'b0 : !ok;
    endfunction

    // Driver: present one request and queue its expected result.
    task automatic send(input logic [1:0] cp, input logic [1:0] mpp, input logic mprv,
                        input logic sum, input logic mxr, input logic xon,
                        input logic [1:0] k, input logic ifp, input logic [4:0] f,
                        input logic lvl, input logic [9:0] p0, input logic [31:0] noise,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_valid   = 1'b1;
        cur_priv    = cp;
        status      = (noise & ~FIELD_MASK) | ({30'd0, mpp} << 11) | ({31'd0, mprv} << 17)
                    | ({31'd0, sum} << 18) | ({31'd0, mxr} << 19);
        xlate_on    = xon;
        kind        = k;
        ifetch_port = ifp;
        pte_flags   = f;
        pte_level   = lvl;
        pte_ppn0    = p0;
        predict(cp, mpp, mprv, sum, mxr, xon, k, ifp, f, lvl, p0, e.byp, e.flt);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare every result against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R1 unexpected rsp_valid: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, rsp_bypass, e.byp, "bypass");
                check(e.tag, rsp_fault, e.flt, "fault");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        logic hb, hf;
        repeat (3) @(negedge clk);
        check("R1", rsp_valid, 1'b0, "reset valid");
        check("R1", rsp_bypass, 1'b0, "reset bypass");
        check("R1", rsp_fault, 1'b0, "reset fault");
        @(negedge clk); rst_n = 1'b1;

        // R3 translation off, and governed as machine
        send(2'd0, 2'd0, 0, 0, 0, 0, 2'd0, 0, V|R|U, 0, 0, 0, "R3");
        send(2'd3, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R, 0, 0, 0, "R3");
        // R4 machine fetch port ignores modify-privilege
        send(2'd3, 2'd0, 1, 0, 0, 1, 2'd0, 1, V|R|U, 0, 0, 0, "R4");
        send(2'd3, 2'd0, 1, 0, 0, 1, 2'd0, 0, V|R|U, 0, 0, 0, "R4");
        send(2'd3, 2'd0, 1, 0, 0, 1, 2'd0, 0, V|R, 0, 0, 0, "R4");
        // R2 previous privilege used for data, not for execute
        send(2'd3, 2'd3, 1, 0, 0, 1, 2'd1, 0, 5'd0, 0, 0, 0, "R2");
        send(2'd3, 2'd1, 1, 0, 0, 1, 2'd2, 0, 5'd0, 0, 0, 0, "R2");
        send(2'd1, 2'd0, 1, 0, 0, 1, 2'd0, 0, V|R|U, 0, 0, 0, "R2");
        send(2'd1, 2'd0, 1, 0, 0, 1, 2'd2, 0, V|X|U, 0, 0, 0, "R2");
        // R5 bypass masks an invalid entry
        send(2'd1, 2'd0, 0, 0, 0, 0, 2'd1, 0, 5'd0, 1, 10'h3FF, 0, "R5");
        // R6 invalid entry
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd0, 0, R|W|X, 0, 0, 0, "R6");
        // R7 user level on non-user page, then allowed
        send(2'd0, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R, 0, 0, 0, "R7");
        send(2'd0, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R|U, 0, 0, 0, "R7");
        // R8 supervisor on user page
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R|U, 0, 0, 0, "R8");
        send(2'd1, 2'd0, 0, 1, 0, 1, 2'd0, 0, V|R|U, 0, 0, 0, "R8");
        // R9 superpage alignment
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R, 1, 10'd5, 0, "R9");
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R, 0, 10'd5, 0, "R9");
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R, 1, 10'd0, 0, "R9");
        idle();
        idle();
        hb = rsp_bypass; hf = rsp_fault;
        idle();
        check("R1", rsp_valid, 1'b0, "idle valid");
        check("R1", rsp_bypass, hb, "hold bypass");
        check("R1", rsp_fault, hf, "hold fault");

        // R10 per-kind permissions
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|X, 0, 0, 0, "R10");
        send(2'd1, 2'd0, 0, 0, 1, 1, 2'd0, 0, V|X, 0, 0, 0, "R10");
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd1, 0, V|R|W, 0, 0, 0, "R10");
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd1, 0, V|R|X, 0, 0, 0, "R10");
        send(2'd0, 2'd0, 0, 0, 0, 1, 2'd2, 1, V|X|U, 0, 0, 0, "R10");
        send(2'd0, 2'd0, 0, 0, 0, 1, 2'd2, 1, V|R|W|U, 0, 0, 0, "R10");
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd3, 0, V|R|W|X, 0, 0, 0, "R10");
        // R11 unrelated status bits set everywhere
        send(2'd1, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|R, 0, 0, 32'hFFFF_FFFF, "R11");
        send(2'd0, 2'd0, 0, 0, 0, 1, 2'd0, 0, V|X|U, 0, 0, 32'hFFFF_FFFF, "R11");
        send(2'd3, 2'd0, 0, 0, 0, 1, 2'd1, 0, V|W|U, 0, 0, 32'hFFFF_FFFF, "R11");
        idle();
        repeat (3) idle();
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 missing responses: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        report();
    end
endmodule